// File: doc/BRIEF.md
# Receiver Line Presence Detector

This block watches a group of receiver lines and reports whether any of them carries a proper signalling level. External comparators classify each line into a two-bit level code every clock. The block turns those codes into a single indicator that drops low only after every line has stayed in the dead band near zero volts for a long qualification window. It comes back high after a short confirmation run once any line shows a valid positive or negative level. Codes in the grey zone between the bands leave the indicator and the qualification count where they are.

The indicator is a plain status pin. It has no mode or power inputs and keeps working whatever power state the surrounding interface is in. Power-management logic reads it to decide when the interface may sleep. Both delays are parameters counted in clock cycles. At 50 MHz, a 30 µs window is 1500 cycles, and a confirmation of 1 µs or less is at most 50 cycles. There is no data stream through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `rx_line_presence`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it is released, `line_ok_o` is 0 (no valid line) and both delay counts are empty.
- R2: Each channel i uses bits [2i+1:2i] of `lvl_code_i`. The codes are 2'b00 dead band (invalid), 2'b01 valid positive, 2'b10 valid negative and 2'b11 grey zone (indeterminate). Both 2'b01 and 2'b10 count as valid.
- R3: `line_ok_o` goes to 1 at the RISE_CYC-th consecutive clock edge at which at least one channel shows a valid code. A valid run shorter than RISE_CYC edges leaves it at 0.
- R4: `line_ok_o` goes to 0 at the edge that completes FALL_CYC counted edges at which every channel shows 2'b00.
- R5: An edge with no valid code and at least one 2'b11 code neither advances nor restarts the dead-band count. The indicator holds its value.
- R6: An edge with any valid code empties the dead-band count. A later fall then needs a full FALL_CYC dead-band edges again.
- R7: An edge with no valid code empties the confirmation run, so a rise needs RISE_CYC valid edges in an unbroken row.
- R8: `line_ok_o` changes at no edge other than those described in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_code_i | input | 2*NUM_CH | Per-channel level codes, channel i in bits [2i+1:2i] |
| line_ok_o | output | 1 | 1 when some line is valid; 0 when all lines are qualified as invalid |

## Verification
Each code applied before clock edge n takes effect at that edge. The indicator shows the result from just after edge n. A rise therefore appears right after the RISE_CYC-th valid edge, and a fall right after the FALL_CYC-th counted dead-band edge. The bench drives codes on the falling edge and updates its reference model at the rising edge. It compares the indicator at the next falling edge, one cycle after each stimulus. This gives exact edge-count checks: one cycle before the threshold the old value must still be present, and at the threshold the new value must appear.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {
    LVL_DEAD  = 2'b00,
    LVL_POS   = 2'b01,
    LVL_NEG   = 2'b10,
    LVL_GREY  = 2'b11
  } lvl_code_t;
endpackage

// File: rtl/lvl_classify.sv
module lvl_classify #(
  parameter int NUM_CH = 3
) (
  input  logic [2*NUM_CH-1:0] codes_i,
  output logic                any_valid_o,
  output logic                all_dead_o
);
  import lvl_pkg::*;

  logic [NUM_CH-1:0] ch_valid;
  logic [NUM_CH-1:0] ch_dead;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lvl_code_t c;
    assign c          = lvl_code_t'(codes_i[2*g +: 2]);
    assign ch_valid[g] = (c == LVL_POS) || (c == LVL_NEG);
    assign ch_dead[g]  = (c == LVL_DEAD);
  end

  assign any_valid_o = |ch_valid;
  assign all_dead_o  = &ch_dead;
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr_i)      cnt <= '0;
    else if (inc_i && cnt < TOP) cnt <= cnt + 1'b1;
  end

  assign hit_o = inc_i && !clr_i && (cnt >= TOP);

  // R6 and R7: a clearing edge leaves the run empty
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0));
  // R5: neither increment nor clear keeps the run unchanged
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt));
  p_run_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
endmodule

// File: rtl/rx_line_presence.sv
module rx_line_presence #(
  parameter int NUM_CH   = 3,
  parameter int RISE_CYC = 40,
  parameter int FALL_CYC = 1500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_CH-1:0] lvl_code_i,
  output logic                line_ok_o
);
  logic any_valid, all_dead;
  logic rise_hit, fall_hit;
  logic ok_q;

  lvl_classify #(.NUM_CH(NUM_CH)) u_cls (
    .codes_i     (lvl_code_i),
    .any_valid_o (any_valid),
    .all_dead_o  (all_dead)
  );

  // confirmation run: valid edges in a row
  run_counter #(.LIMIT(RISE_CYC)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (any_valid),
    .clr_i (!any_valid),
    .hit_o (rise_hit)
  );

  // dead-band qualification: grey edges hold, valid edges clear
  run_counter #(.LIMIT(FALL_CYC)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (all_dead),
    .clr_i (any_valid),
    .hit_o (fall_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ok_q <= 1'b0;
    else if (rise_hit) ok_q <= 1'b1;
    else if (fall_hit) ok_q <= 1'b0;
  end

  assign line_ok_o = ok_q;

  p_rise_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_ok_o) |-> $past(any_valid));
  p_fall_on_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_ok_o) |-> $past(all_dead));
  p_grey_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_valid && !all_dead) |=> $stable(line_ok_o));
  p_valid_never_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_valid |=> !$fell(line_ok_o));
endmodule

// File: tb/test_rx_line_presence.sv
module test_rx_line_presence;
  localparam int NCH  = 3;
  localparam int RISE = 3;
  localparam int FALL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NCH-1:0] lvl = '0;
  logic ok;

  int total = 0, bad = 0;
  bit done = 0;
  int m_vrun = 0, m_drun = 0;
  logic m_ok = 1'b0;
  string phase = "R8";

  always #10 clk = ~clk;

  rx_line_presence #(.NUM_CH(NCH), .RISE_CYC(RISE), .FALL_CYC(FALL)) i_rx_line_presence (
    .clk(clk), .rst_n(rst_n), .lvl_code_i(lvl), .line_ok_o(ok)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: line_ok actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, applied once per rising edge
  task automatic model(input logic [2*NCH-1:0] c);
    bit v = 0, d = 1;
    for (int i = 0; i < NCH; i++) begin
      if (c[2*i +: 2] == 2'b01 || c[2*i +: 2] == 2'b10) v = 1;
      if (c[2*i +: 2] != 2'b00) d = 0;
    end
    if (v) begin
      m_drun = 0; m_vrun++;
      if (m_vrun >= RISE) m_ok = 1'b1;
    end else begin
      m_vrun = 0;
      if (d) begin
        m_drun++;
        if (m_drun >= FALL) m_ok = 1'b0;
      end
    end
  endtask

  // called at a falling edge: drive, take one rising edge, compare at next fall
  task automatic step(input logic [2*NCH-1:0] c);
    lvl = c;
    @(posedge clk);
    model(c);
    @(negedge clk);
    chk(ok, m_ok, phase);
  endtask

  task automatic run(input logic [2*NCH-1:0] c, input int n);
    for (int i = 0; i < n; i++) step(c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ok, 1'b0, "R1");
    rst_n = 1'b1;
    step(6'b00_00_00);
    chk(ok, 1'b0, "R1");

    phase = "R7";
    run(6'b00_00_01, RISE - 1);
    chk(ok, 1'b0, "R7");
    step(6'b00_11_00);
    run(6'b00_00_01, RISE - 1);
    chk(ok, 1'b0, "R7");

    phase = "R3";
    step(6'b00_00_01);
    chk(ok, 1'b1, "R3");

    phase = "R4";
    run(6'b00_00_00, FALL - 1);
    chk(ok, 1'b1, "R4");
    step(6'b00_00_00);
    chk(ok, 1'b0, "R4");

    phase = "R2";
    run(6'b10_00_00, RISE - 1);
    chk(ok, 1'b0, "R2");
    step(6'b10_00_00);
    chk(ok, 1'b1, "R2");

    phase = "R5";
    run(6'b00_00_00, 6);
    run(6'b11_00_00, 20);
    chk(ok, 1'b1, "R5");
    run(6'b11_11_11, 10);
    run(6'b00_00_00, 5);
    chk(ok, 1'b1, "R5");
    step(6'b00_00_00);
    chk(ok, 1'b0, "R5");
    run(6'b00_11_00, 15);
    chk(ok, 1'b0, "R5");

    phase = "R6";
    run(6'b01_10_00, RISE);
    chk(ok, 1'b1, "R6");
    run(6'b00_00_00, FALL - 2);
    step(6'b00_01_00);
    run(6'b00_00_00, FALL - 1);
    chk(ok, 1'b1, "R6");
    step(6'b00_00_00);
    chk(ok, 1'b0, "R6");

    phase = "R8";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[15:13] < 3'd4) step(6'b00_00_00);
        else if (lf[15:13] == 3'd4) step(lf[5:0]);
        else step({lf[1:0] & 2'b11, 2'b00, lf[3:2] & {1'b1, lf[4]}});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule